// File: doc/BRIEF.md
# RGB to YCbCr Color Converter

This block converts a stream of 8-bit R, G, B pixels into Y, Cb, Cr samples with a 3x3 signed matrix. Pixels enter and leave through valid/ready handshakes. Each of the nine matrix weights is a 10-bit signed fraction. Three configuration words carry the weights, one word per output row. Besides the programmed matrix, the block holds two built-in matrices. It picks between them from the active line count of the display mode.

The configuration covers several things: whether the programmed or a built-in matrix is used, the active line count, full or limited output range, and a flag that says whether the incoming RGB is full range. The block captures this configuration into shadow registers only on a frame-start pulse. A frame therefore never mixes two settings. Each pixel carries its own copy of the range choice down the three-stage pipeline, so pixels already in flight finish with the setting they entered with.

Top module: `csc_rgb2ycc`

## Requirements
- R1: A weight is a 10-bit two's-complement number whose value is code/512 (range -512..511). In a row word, the R weight sits in bits 29..20, the G weight in bits 19..10 and the B weight in bits 9..0. Row words are Y (`cfg_row_y[29:0]`), Cb (`cfg_row_cb`) and Cr (`cfg_row_cr`).
- R2: Bit 30 of `cfg_row_y` set means the RGB input is full range and each channel enters the products unchanged. Clear means 16 is subtracted from each channel before multiplication.
- R3: With `cfg_custom` set, the programmed rows are used. With it clear, a built-in matrix is used. When the captured line count is below 720 the matrix is Y (131,258,50), Cb (-75,-148,224), Cr (224,-188,-36). Otherwise it is Y (94,314,32), Cb (-52,-173,225), Cr (225,-204,-20). All values are codes in units of 1/512.
- R4: Each output channel first forms acc = wR*r + wG*g + wB*b, using the channel values after R2. The result before offset is floor((acc + 256) / 512).
- R5: With `cfg_qfull` clear (limited range), Y gets +16 and is clamped to 16..235. Cb and Cr get +128 and are clamped to 16..240.
- R6: With `cfg_qfull` set (full range), Y gets +0, Cb and Cr get +128, and all three are clamped to 0..255.
- R7: With `out_ready` held high, a pixel accepted on a clock edge appears on the outputs after the second following edge, three registers deep. One pixel can be accepted per cycle.
- R8: While `out_valid` is high and `out_ready` low, the outputs hold their data and `in_ready` is low.
- R9: Configuration inputs are captured only on an edge where `frame_start` is high. Changes without that pulse have no effect on the results.
- R10: Synchronous reset clears `out_valid` and raises `in_ready`. The captured configuration becomes: built-in matrix, line count 0, limited output range, limited-range RGB input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Captures the configuration inputs |
| cfg_row_y | input | 31 | Y row weights in bits 29..0, full-range RGB flag in bit 30 |
| cfg_row_cb | input | 30 | Cb row weights |
| cfg_row_cr | input | 30 | Cr row weights |
| cfg_custom | input | 1 | 1 selects the programmed rows, 0 a built-in matrix |
| cfg_lines | input | 12 | Active line count of the mode |
| cfg_qfull | input | 1 | 1 selects full output range |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_r | input | 8 | Red |
| in_g | input | 8 | Green |
| in_b | input | 8 | Blue |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_y | output | 8 | Luma |
| out_cb | output | 8 | Blue-difference chroma |
| out_cr | output | 8 | Red-difference chroma |

## Verification
The assertions assume `out_ready` may fall at any time while `out_valid` is high. They also assume `frame_start` can arrive at any cycle, and that the range flag seen at the output stage is the one that travelled with the pixel. The stimulus never pulses `frame_start` in a cycle that also offers a pixel, so the bench always knows which configuration a pixel was accepted under. It sweeps grids of R, G, B values that include 0 and 255. These sweeps run under every combination of the range flags, for programmed matrices with extreme weights and for both built-in matrices on either side of the 720-line threshold.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int COEF_W   = 10;
  localparam int FRAC_W   = COEF_W - 1;
  localparam int ROW_W    = 3 * COEF_W;
  localparam int HD_LINES = 720;

  typedef logic signed [COEF_W-1:0] coef_t;

  // Built-in weights, index = row*3 + column (row: Y,Cb,Cr; column: R,G,B)
  function automatic coef_t builtin_coef(input logic hd, input int idx);
    int v;
    v = 0;
    if (hd) begin
      case (idx)
        0: v = 94;   1: v = 314;  2: v = 32;
        3: v = -52;  4: v = -173; 5: v = 225;
        6: v = 225;  7: v = -204; 8: v = -20;
        default: v = 0;
      endcase
    end else begin
      case (idx)
        0: v = 131;  1: v = 258;  2: v = 50;
        3: v = -75;  4: v = -148; 5: v = 224;
        6: v = 224;  7: v = -188; 8: v = -36;
        default: v = 0;
      endcase
    end
    return coef_t'(v);
  endfunction
endpackage

// File: rtl/csc_coef_bank.sv
module csc_coef_bank
  import csc_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_start,
  input  logic [ROW_W:0]        row_y,
  input  logic [ROW_W-1:0]      row_cb,
  input  logic [ROW_W-1:0]      row_cr,
  input  logic                  custom,
  input  logic [LINE_W-1:0]     lines,
  input  logic                  qfull,
  output logic [9*COEF_W-1:0]   coef_flat,
  output logic                  rgb_full,
  output logic                  q_act
);
  logic [ROW_W:0]   sh_y;
  logic [ROW_W-1:0] sh_cb, sh_cr;
  logic             sh_custom, sh_hd, sh_q;
  logic [ROW_W-1:0] rows [3];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_y      <= '0;
      sh_cb     <= '0;
      sh_cr     <= '0;
      sh_custom <= 1'b0;
      sh_hd     <= 1'b0;
      sh_q      <= 1'b0;
    end else if (frame_start) begin
      sh_y      <= row_y;
      sh_cb     <= row_cb;
      sh_cr     <= row_cr;
      sh_custom <= custom;
      sh_hd     <= (lines >= LINE_W'(HD_LINES));
      sh_q      <= qfull;
    end
  end

  assign rows[0]  = sh_y[ROW_W-1:0];
  assign rows[1]  = sh_cb;
  assign rows[2]  = sh_cr;
  assign rgb_full = sh_y[ROW_W];
  assign q_act    = sh_q;

  for (genvar k = 0; k < 3; k++) begin : g_row
    for (genvar j = 0; j < 3; j++) begin : g_col
      assign coef_flat[(k*3+j)*COEF_W +: COEF_W] =
        sh_custom ? rows[k][ROW_W-1-j*COEF_W -: COEF_W] : builtin_coef(sh_hd, k*3+j);
    end
  end
endmodule

// File: rtl/csc_dot.sv
module csc_dot
  import csc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int XW     = DW + 1,
  parameter int PROD_W = XW + COEF_W,
  parameter int ACC_W  = PROD_W + 2,
  parameter int RES_W  = ACC_W - FRAC_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic [3*XW-1:0]         x_flat,
  input  logic [3*COEF_W-1:0]     c_row,
  output logic signed [RES_W-1:0] res
);
  localparam logic signed [ACC_W-1:0] RND = ACC_W'(1 << (FRAC_W - 1));

  logic signed [PROD_W-1:0] prod [3];
  logic signed [ACC_W-1:0]  acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) prod[i] <= '0;
    end else if (adv) begin
      for (int i = 0; i < 3; i++)
        prod[i] <= PROD_W'($signed(x_flat[i*XW +: XW])) *
                   PROD_W'($signed(c_row[i*COEF_W +: COEF_W]));
    end
  end

  always_comb acc = ACC_W'(prod[0]) + ACC_W'(prod[1]) + ACC_W'(prod[2]) + RND;

  always_ff @(posedge clk) begin
    if (rst)      res <= '0;
    else if (adv) res <= RES_W'(acc >>> FRAC_W);
  end
endmodule

// File: rtl/csc_clamp.sv
module csc_clamp #(
  parameter int DW    = 8,
  parameter int RES_W = 12,
  parameter bit LUMA  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic                    qfull,
  input  logic signed [RES_W-1:0] v,
  output logic [DW-1:0]           o
);
  localparam int SC     = DW - 8;
  localparam int T_W    = RES_W + 2;
  localparam int OLIM_I = (LUMA ? 16 : 128) << SC;
  localparam int OFUL_I = (LUMA ? 0 : 128) << SC;
  localparam int LO_I   = 16 << SC;
  localparam int HI_I   = (LUMA ? 235 : 240) << SC;
  localparam int MAX_I  = (1 << DW) - 1;
  localparam logic signed [T_W-1:0] OFS_LIM  = T_W'(OLIM_I);
  localparam logic signed [T_W-1:0] OFS_FULL = T_W'(OFUL_I);
  localparam logic signed [T_W-1:0] LO_LIM   = T_W'(LO_I);
  localparam logic signed [T_W-1:0] HI_LIM   = T_W'(HI_I);
  localparam logic signed [T_W-1:0] MAX_FULL = T_W'(MAX_I);

  logic signed [T_W-1:0] t, lo, hi;

  always_comb begin
    t  = T_W'(v) + (qfull ? OFS_FULL : OFS_LIM);
    lo = qfull ? '0 : LO_LIM;
    hi = qfull ? MAX_FULL : HI_LIM;
  end

  always_ff @(posedge clk) begin
    if (rst) o <= '0;
    else if (adv) begin
      if (t < lo)      o <= lo[DW-1:0];
      else if (t > hi) o <= hi[DW-1:0];
      else             o <= t[DW-1:0];
    end
  end
endmodule

// File: rtl/csc_rgb2ycc.sv
module csc_rgb2ycc
  import csc_pkg::*;
#(
  parameter int DW     = 8,
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [ROW_W:0]    cfg_row_y,
  input  logic [ROW_W-1:0]  cfg_row_cb,
  input  logic [ROW_W-1:0]  cfg_row_cr,
  input  logic              cfg_custom,
  input  logic [LINE_W-1:0] cfg_lines,
  input  logic              cfg_qfull,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_r,
  input  logic [DW-1:0]     in_g,
  input  logic [DW-1:0]     in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_y,
  output logic [DW-1:0]     out_cb,
  output logic [DW-1:0]     out_cr
);
  localparam int XW       = DW + 1;
  localparam int PROD_W   = XW + COEF_W;
  localparam int ACC_W    = PROD_W + 2;
  localparam int RES_W    = ACC_W - FRAC_W;
  localparam int IN_OFS_I = 16 << (DW - 8);
  localparam logic [XW-1:0] IN_OFS = XW'(IN_OFS_I);

  logic [9*COEF_W-1:0] coef_flat;
  logic                rgb_full, q_act;
  logic [9*COEF_W+1:0] cfg_live;
  logic [3*XW-1:0]     x_flat;
  logic [3*RES_W-1:0]  res_flat;
  logic [DW-1:0]       ycc [3];
  logic                adv, v1, v2, q1, q2, q_out;

  csc_coef_bank #(.LINE_W(LINE_W)) u_bank (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .row_y(cfg_row_y), .row_cb(cfg_row_cb), .row_cr(cfg_row_cr),
    .custom(cfg_custom), .lines(cfg_lines), .qfull(cfg_qfull),
    .coef_flat(coef_flat), .rgb_full(rgb_full), .q_act(q_act)
  );

  assign cfg_live = {rgb_full, q_act, coef_flat};
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_comb begin
    x_flat[0*XW +: XW] = {1'b0, in_r} - (rgb_full ? '0 : IN_OFS);
    x_flat[1*XW +: XW] = {1'b0, in_g} - (rgb_full ? '0 : IN_OFS);
    x_flat[2*XW +: XW] = {1'b0, in_b} - (rgb_full ? '0 : IN_OFS);
  end

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    csc_dot #(.DW(DW), .XW(XW), .PROD_W(PROD_W), .ACC_W(ACC_W), .RES_W(RES_W)) u_dot (
      .clk(clk), .rst(rst), .adv(adv), .x_flat(x_flat),
      .c_row(coef_flat[ch*3*COEF_W +: 3*COEF_W]),
      .res(res_flat[ch*RES_W +: RES_W])
    );
    csc_clamp #(.DW(DW), .RES_W(RES_W), .LUMA(ch == 0)) u_clamp (
      .clk(clk), .rst(rst), .adv(adv), .qfull(q2),
      .v(res_flat[ch*RES_W +: RES_W]), .o(ycc[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {v1, v2, out_valid} <= '0;
      {q1, q2, q_out}     <= '0;
    end else if (adv) begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
      q1        <= q_act;
      q2        <= q1;
      q_out     <= q2;
    end
  end

  assign out_y  = ycc[0];
  assign out_cb = ycc[1];
  assign out_cr = ycc[2];
endmodule

// File: rtl/csc_rgb2ycc_chk.sv
module csc_rgb2ycc_chk
  import csc_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                frame_start,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic                q_out,
  input logic [DW-1:0]       out_y,
  input logic [DW-1:0]       out_cb,
  input logic [DW-1:0]       out_cr,
  input logic [9*COEF_W+1:0] cfg_live
);
  localparam logic [DW-1:0] LO  = DW'(16 << (DW - 8));
  localparam logic [DW-1:0] YHI = DW'(235 << (DW - 8));
  localparam logic [DW-1:0] CHI = DW'(240 << (DW - 8));

  AST_LUMA_LIMITED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !q_out) |-> (out_y >= LO && out_y <= YHI)); // R5

  AST_CHROMA_LIMITED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !q_out) |-> (out_cb >= LO && out_cb <= CHI && out_cr >= LO && out_cr <= CHI)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_y, out_cb, out_cr}))); // R8

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R8

  AST_CFG_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(cfg_live)); // R9
endmodule

bind csc_rgb2ycc csc_rgb2ycc_chk #(.DW(DW)) u_chk (.*);

// File: tb/csc_rgb2ycc_test.sv
`timescale 1ns/1ps
module csc_rgb2ycc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [30:0] cfg_row_y = '0;
  logic [29:0] cfg_row_cb = '0, cfg_row_cr = '0;
  logic        cfg_custom = 1'b0;
  logic [11:0] cfg_lines = '0;
  logic        cfg_qfull = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [7:0]  in_r = '0, in_g = '0, in_b = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [7:0]  out_y, out_cb, out_cr;

  always #2.5 clk = ~clk;

  csc_rgb2ycc uut (.*);

  int n_tests = 0, n_fail = 0;
  int bm_c [9];
  bit bm_rgbf = 0, bm_q = 0;
  logic [23:0] expq [$];
  string tagq [$];
  string cur_tag = "R10";
  bit hold_pend = 0;
  logic [23:0] held;

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int sx10(logic [9:0] w);
    return w[9] ? int'(w) - 1024 : int'(w);
  endfunction

  function automatic int builtin(bit hd, int i);
    int sd [9] = '{131, 258, 50, -75, -148, 224, 224, -188, -36};
    int hv [9] = '{94, 314, 32, -52, -173, 225, 225, -204, -20};
    return hd ? hv[i] : sd[i];
  endfunction

  function automatic logic [29:0] row(int a, int b, int c);
    logic [9:0] ta, tb, tc;
    ta = a[9:0]; tb = b[9:0]; tc = c[9:0];
    return {ta, tb, tc};
  endfunction

  function automatic logic [23:0] model(int r, int g, int b);
    int x [3];
    int o [3];
    x[0] = bm_rgbf ? r : r - 16;
    x[1] = bm_rgbf ? g : g - 16;
    x[2] = bm_rgbf ? b : b - 16;
    for (int k = 0; k < 3; k++) begin
      int acc, v, lo, hi;
      acc = bm_c[k*3] * x[0] + bm_c[k*3+1] * x[1] + bm_c[k*3+2] * x[2];
      v = (acc + 256) >>> 9;
      v = v + ((k == 0) ? (bm_q ? 0 : 16) : 128);
      lo = bm_q ? 0 : 16;
      hi = bm_q ? 255 : ((k == 0) ? 235 : 240);
      if (v < lo) v = lo;
      if (v > hi) v = hi;
      o[k] = v;
    end
    return {o[0][7:0], o[1][7:0], o[2][7:0]};
  endfunction

  task automatic step(input bit v, input int r, input int g, input int b,
                      input bit ordy, input bit fs, output bit took);
    logic [29:0] w [3];
    @(negedge clk);
    in_valid = v; in_r = r[7:0]; in_g = g[7:0]; in_b = b[7:0];
    out_ready = ordy; frame_start = fs;
    #1;
    if (hold_pend) begin
      chk("R8 held valid", int'(out_valid), 1);
      chk("R8 held data", int'({out_y, out_cb, out_cr}), int'(held));
    end
    if (out_valid && !out_ready) chk("R8 in_ready low", int'(in_ready), 0);
    hold_pend = out_valid && !out_ready;
    held = {out_y, out_cb, out_cr};
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk("R7 unexpected output", 1, 0);
      else begin
        logic [23:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(t, int'({out_y, out_cb, out_cr}), int'(e));
      end
    end
    took = v && in_ready;
    if (took) begin
      expq.push_back(model(r, g, b));
      tagq.push_back(cur_tag);
    end
    if (fs) begin
      w[0] = cfg_row_y[29:0]; w[1] = cfg_row_cb; w[2] = cfg_row_cr;
      for (int k = 0; k < 3; k++)
        for (int j = 0; j < 3; j++)
          bm_c[k*3+j] = cfg_custom ? sx10(w[k][29-10*j -: 10]) : builtin(cfg_lines >= 720, k*3+j);
      bm_rgbf = cfg_row_y[30];
      bm_q    = cfg_qfull;
    end
  endtask

  task automatic drain();
    bit t;
    for (int k = 0; k < 40 && expq.size() > 0; k++) step(0, 0, 0, 0, 1, 0, t);
    chk({cur_tag, " drained"}, expq.size(), 0);
  endtask

  task automatic sweep(int stp, string tag, bit bp);
    cur_tag = tag;
    for (int r = 0; r < 256; r += stp)
      for (int g = 0; g < 256; g += stp)
        for (int b = 0; b < 256; b += stp) begin
          bit t;
          do step(1, r, g, b, bp ? ($urandom % 4 != 0) : 1'b1, 0, t); while (!t);
        end
    drain();
  endtask

  task automatic setcfg(bit custom, int lines, bit q, bit rgbf,
                        logic [29:0] wy, logic [29:0] wcb, logic [29:0] wcr);
    bit t;
    cfg_custom = custom; cfg_lines = lines[11:0]; cfg_qfull = q;
    cfg_row_y = {rgbf, wy}; cfg_row_cb = wcb; cfg_row_cr = wcr;
    step(0, 0, 0, 0, 1, 1, t);
    step(0, 0, 0, 0, 1, 0, t);
  endtask

  logic [29:0] m1y, m1b, m1r, m2y, m2b, m2r;

  initial begin
    bit t;
    m1y = row(511, -512, 1);  m1b = row(-1, 255, -256); m1r = row(100, -300, 400);
    m2y = row(77, 150, 29);   m2b = row(-43, -85, 128); m2r = row(128, -107, -21);
    for (int i = 0; i < 9; i++) bm_c[i] = builtin(0, i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 out_valid after reset", int'(out_valid), 0);
    chk("R10 in_ready after reset", int'(in_ready), 1);
    sweep(51, "R10 default config", 0);

    setcfg(1, 1080, 0, 1, m2y, m2b, m2r);  sweep(17, "R4 R5 custom limited", 0);
    setcfg(1, 1080, 1, 1, m2y, m2b, m2r);  sweep(17, "R4 R6 custom full", 0);
    setcfg(1, 480, 1, 0, m2y, m2b, m2r);   sweep(51, "R2 limited rgb full out", 0);
    setcfg(1, 480, 0, 0, m2y, m2b, m2r);   sweep(51, "R2 R5 limited rgb", 0);
    setcfg(1, 480, 1, 1, m1y, m1b, m1r);   sweep(51, "R1 extreme weights full", 0);
    setcfg(1, 480, 0, 0, m1y, m1b, m1r);   sweep(51, "R1 extreme weights limited", 0);

    setcfg(0, 480, 0, 1, m1y, m1b, m1r);   sweep(51, "R3 builtin 480", 0);
    setcfg(0, 719, 1, 1, m1y, m1b, m1r);   sweep(51, "R3 builtin 719", 0);
    setcfg(0, 720, 0, 1, m1y, m1b, m1r);   sweep(51, "R3 builtin 720", 0);
    setcfg(0, 1080, 1, 1, m1y, m1b, m1r);  sweep(51, "R3 builtin 1080", 0);

    // R9: change every setting without a frame-start pulse
    setcfg(1, 480, 0, 1, m2y, m2b, m2r);
    cfg_row_y = {1'b0, m1y}; cfg_row_cb = m1b; cfg_row_cr = m1r;
    cfg_custom = 1'b0; cfg_lines = 12'd1080; cfg_qfull = 1'b1;
    sweep(51, "R9 no capture without frame_start", 0);

    // R7: latency of a lone pixel
    cur_tag = "R7 latency data";
    step(1, 200, 100, 50, 1, 0, t);
    step(0, 0, 0, 0, 1, 0, t); chk("R7 not valid after 1", int'(out_valid), 0);
    step(0, 0, 0, 0, 1, 0, t); chk("R7 not valid after 2", int'(out_valid), 0);
    step(0, 0, 0, 0, 1, 0, t); chk("R7 valid after 3", int'(out_valid), 1);
    drain();

    setcfg(1, 480, 1, 1, m2y, m2b, m2r);   sweep(17, "R8 backpressure", 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule